// File: doc/BRIEF.md
# Paced Energy Pulse Output Spreader

The block takes pulse-update bits for two energy pulse pins (V and W) that a compute engine writes in a quick burst once per calculation pass. It replays them one at a time, evenly spaced, across the multiplexer frame. Each channel holds its updates in a small one-bit queue. A slot timer restarts on every frame-start strobe. Time advances only on clock-enable ticks, and the spacing is a programmed number of four-tick units. In each slot the oldest queued bit is moved onto the channel's level.

Two optional shaping steps follow the level. The first caps the active time of each pulse in proportion to the slot spacing. The second sets the output polarity, which is active low unless inverted. A programmed spacing of zero turns the queues off, and every write then reaches the pins directly. The configuration is captured on each frame-start strobe and holds for the whole frame. If the queue is full when a write arrives, the write is lost and a sticky flag is raised. The next frame start clears that flag.

Top module: `pulse_spreader`

## Requirements
- R1: After reset both pins are high, the overflow flag is low, the captured spacing is 0 (direct mode), the captured width code is 255 and the captured invert bit is 0.
- R2: In direct mode (captured spacing 0) a write sets each channel's level to its bit (1 = active, 0 = inactive). The pin shows the new level on the next cycle whatever the tick input is.
- R3: In queued mode (captured spacing I > 0) each write appends its V bit and its W bit to that channel's 8-entry queue. The queue plays out first in, first out. Each played bit sets the level (1 active, 0 inactive) and an empty slot leaves the level as it is.
- R4: The slot timer is loaded with 4·I on frame start and counts down on each tick cycle. On a tick in which it reads 1, a slot occurs and the timer reloads. The k-th slot therefore falls on the (4·I·k)-th tick after the strobe and the pin changes right after it. With no ticks the pins hold.
- R5: Frame start empties both queues, so updates that have not played are lost. With a 1950-tick frame and six updates written at its start, I = 81 plays all six. I = 82 loses the sixth.
- R6: In queued mode with width code M < 255, an active level returns to inactive after (2·M+1)·4·I ticks. It stays inactive until a later played bit of 1.
- R7: With width code 255, or in direct mode, an active level has no time limit.
- R8: With the captured invert bit 0 the pin is the inverse of the level. With it at 1 the pin equals the level.
- R9: Spacing, width code and invert are captured only on frame start and take effect from the next cycle. Changes between strobes have no effect until the next strobe.
- R10: In queued mode a write that finds the queue full (8 entries) is dropped and sets the overflow flag. The flag stays set until the next frame start, which clears it on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_tick | input | 1 | Clock-enable tick; the timer and width counters advance only when it is high |
| frame_start | input | 1 | Multiplexer frame-start strobe |
| upd_wr | input | 1 | Write strobe for one pulse update |
| upd_v | input | 1 | Update bit for the V channel |
| upd_w | input | 1 | Update bit for the W channel |
| cfg_interval | input | 8 | Slot spacing in four-tick units; 0 selects direct mode |
| cfg_maxwidth | input | 8 | Width-limit code; 255 disables the limit |
| cfg_invert | input | 1 | 1 makes the pins active high |
| pulse_v_o | output | 1 | V pulse pin |
| pulse_w_o | output | 1 | W pulse pin |
| fifo_ovf_o | output | 1 | Sticky flag for a dropped write |

## Verification
Most internal faults show up on a pin within one slot spacing. A wrong timer count moves the first pin edge away from tick 4·I after the strobe. A queue that keeps entries past frame start plays a stale bit in the first slot of the next frame. A wrong queue index appears as a wrong level pattern from the first slot onward. A width counter that is off by one moves the release edge by one tick. A dropped-write fault shows up after eight slots as a level from the ninth write, and a non-sticky flag goes low before the next strobe. The bench runs a per-cycle expected model next to directed checks. Any fault that reaches a pin or the flag is therefore reported in the cycle where it first appears.

// File: rtl/ps_pkg.sv
package ps_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_V   = 0;
    localparam int CH_W   = 1;

    typedef enum logic {
        LVL_IDLE   = 1'b0,
        LVL_ACTIVE = 1'b1
    } level_e;
endpackage

// File: rtl/ps_slot_timer.sv
module ps_slot_timer #(
    parameter int IVL_W = 8,
    parameter int MW_W  = 8,
    parameter int UNIT  = 4,
    parameter int CNT_W = 11,
    parameter int LIM_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             frame_start,
    input  logic [IVL_W-1:0] cfg_interval,
    input  logic [MW_W-1:0]  cfg_maxwidth,
    input  logic             cfg_invert,
    output logic             bypass,
    output logic             slot,
    output logic             lim_en,
    output logic [LIM_W-1:0] limit,
    output logic             invert
);
    typedef struct packed {
        logic [IVL_W-1:0] ivl;
        logic [MW_W-1:0]  mw;
        logic             inv;
        logic [CNT_W-1:0] cnt;
        logic [LIM_W-1:0] lim;
    } tmr_st_t;

    tmr_st_t q, d;
    logic    slot_d;

    always_comb begin
        d      = q;
        slot_d = 1'b0;
        if (frame_start) begin
            // capture a fresh configuration snapshot and restart the spacing
            d.ivl = cfg_interval;
            d.mw  = cfg_maxwidth;
            d.inv = cfg_invert;
            d.cnt = CNT_W'(cfg_interval) * CNT_W'(UNIT);
            d.lim = LIM_W'({cfg_maxwidth, 1'b1}) * LIM_W'(cfg_interval) * LIM_W'(UNIT);
        end else if ((q.ivl != '0) && tick) begin
            if (q.cnt == CNT_W'(1)) begin
                slot_d = 1'b1;
                d.cnt  = CNT_W'(q.ivl) * CNT_W'(UNIT);
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ivl <= '0;
            q.mw  <= '1;
            q.inv <= 1'b0;
            q.cnt <= '0;
            q.lim <= '0;
        end else begin
            q <= d;
        end
    end

    assign slot   = slot_d;
    assign bypass = (q.ivl == '0);
    assign lim_en = (q.ivl != '0) && (q.mw != '1);
    assign limit  = q.lim;
    assign invert = q.inv;
endmodule

// File: rtl/ps_bit_fifo.sv
module ps_bit_fifo #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic push,
    input  logic din,
    input  logic pop,
    output logic dout,
    output logic empty,
    output logic full
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [CW-1:0]    cnt;
    } fifo_st_t;

    fifo_st_t      q, d;
    logic [CW-1:0] fill;

    always_comb begin
        d    = q;
        fill = clear ? '0 : q.cnt;
        // entry 0 is the head; a pop shifts the rest down by one
        if (!clear && pop && (q.cnt != '0)) begin
            d.mem = q.mem >> 1;
            fill  = q.cnt - CW'(1);
        end
        if (push && (clear || (q.cnt != CW'(DEPTH)))) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == fill) begin
                    d.mem[i] = din;
                end
            end
            fill = fill + CW'(1);
        end
        d.cnt = fill;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dout  = q.mem[0];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
endmodule

// File: rtl/ps_pulse_level.sv
module ps_pulse_level
    import ps_pkg::*;
#(
    parameter int LIM_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             bypass,
    input  logic             wr,
    input  logic             wr_bit,
    input  logic             slot,
    input  logic             fifo_empty,
    input  logic             fifo_bit,
    input  logic             lim_en,
    input  logic [LIM_W-1:0] limit,
    input  logic             invert,
    output logic             pin
);
    typedef struct packed {
        level_e           lvl;
        logic [LIM_W-1:0] wcnt;
    } lvl_st_t;

    lvl_st_t q, d;

    always_comb begin
        d = q;
        if (bypass) begin
            if (wr) begin
                d.lvl  = level_e'(wr_bit);
                d.wcnt = '0;
            end
        end else if (slot && !fifo_empty) begin
            d.lvl  = level_e'(fifo_bit);
            d.wcnt = '0;
        end else if ((q.lvl == LVL_ACTIVE) && lim_en && tick) begin
            if ((q.wcnt + LIM_W'(1)) >= limit) begin
                d.lvl  = LVL_IDLE;
                d.wcnt = '0;
            end else begin
                d.wcnt = q.wcnt + LIM_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lvl  <= LVL_IDLE;
            q.wcnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign pin = invert ? (q.lvl == LVL_ACTIVE) : (q.lvl != LVL_ACTIVE);
endmodule

// File: rtl/pulse_spreader.sv
module pulse_spreader
    import ps_pkg::*;
#(
    parameter int IVL_W = 8,
    parameter int MW_W  = 8,
    parameter int UNIT  = 4,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_tick,
    input  logic             frame_start,
    input  logic             upd_wr,
    input  logic             upd_v,
    input  logic             upd_w,
    input  logic [IVL_W-1:0] cfg_interval,
    input  logic [MW_W-1:0]  cfg_maxwidth,
    input  logic             cfg_invert,
    output logic             pulse_v_o,
    output logic             pulse_w_o,
    output logic             fifo_ovf_o
);
    localparam int CNT_W = IVL_W + $clog2(UNIT) + 1;
    localparam int LIM_W = MW_W + 1 + IVL_W + $clog2(UNIT) + 1;

    typedef struct packed {
        logic ovf;
    } top_st_t;

    logic             bypass;
    logic             slot;
    logic             lim_en;
    logic [LIM_W-1:0] limit;
    logic             invert;
    logic             push;
    logic [NUM_CH-1:0] upd_bits;
    logic [NUM_CH-1:0] head;
    logic [NUM_CH-1:0] empty;
    logic [NUM_CH-1:0] full;
    logic [NUM_CH-1:0] pins;
    top_st_t          q, d;

    assign upd_bits[CH_V] = upd_v;
    assign upd_bits[CH_W] = upd_w;
    assign push           = upd_wr && !bypass;

    ps_slot_timer #(
        .IVL_W(IVL_W), .MW_W(MW_W), .UNIT(UNIT), .CNT_W(CNT_W), .LIM_W(LIM_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (ce_tick),
        .frame_start (frame_start),
        .cfg_interval(cfg_interval),
        .cfg_maxwidth(cfg_maxwidth),
        .cfg_invert  (cfg_invert),
        .bypass      (bypass),
        .slot        (slot),
        .lim_en      (lim_en),
        .limit       (limit),
        .invert      (invert)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ps_bit_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk  (clk),
            .rst_n(rst_n),
            .clear(frame_start),
            .push (push),
            .din  (upd_bits[c]),
            .pop  (slot),
            .dout (head[c]),
            .empty(empty[c]),
            .full (full[c])
        );

        ps_pulse_level #(.LIM_W(LIM_W)) u_level (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (ce_tick),
            .bypass    (bypass),
            .wr        (upd_wr),
            .wr_bit    (upd_bits[c]),
            .slot      (slot),
            .fifo_empty(empty[c]),
            .fifo_bit  (head[c]),
            .lim_en    (lim_en),
            .limit     (limit),
            .invert    (invert),
            .pin       (pins[c])
        );
    end

    always_comb begin
        d = q;
        if (frame_start) begin
            d.ovf = 1'b0;
        end else if (push && (|full)) begin
            d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pulse_v_o  = pins[CH_V];
    assign pulse_w_o  = pins[CH_W];
    assign fifo_ovf_o = q.ovf;
endmodule

// File: rtl/ps_checker.sv
module ps_checker (
    input logic clk,
    input logic rst_n,
    input logic ce_tick,
    input logic frame_start,
    input logic upd_wr,
    input logic upd_v,
    input logic pulse_v_o,
    input logic fifo_ovf_o,
    input logic bypass,
    input logic slot,
    input logic invert
);
    // R10
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !fifo_ovf_o);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ovf_o && !frame_start) |=> fifo_ovf_o);

    // R2
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && upd_wr && !frame_start) |=>
            (pulse_v_o == (invert ? $past(upd_v) : !$past(upd_v))));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(bypass));

    // R4
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !slot && !ce_tick && !frame_start) |=> $stable(pulse_v_o));
endmodule

bind pulse_spreader ps_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_tick    (ce_tick),
    .frame_start(frame_start),
    .upd_wr     (upd_wr),
    .upd_v      (upd_v),
    .pulse_v_o  (pulse_v_o),
    .fifo_ovf_o (fifo_ovf_o),
    .bypass     (bypass),
    .slot       (slot),
    .invert     (invert)
);

// File: tb/tb_pulse_spreader.sv
module tb_pulse_spreader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_tick = 1'b0;
    logic       frame_start = 1'b0;
    logic       upd_wr = 1'b0;
    logic       upd_v = 1'b0;
    logic       upd_w = 1'b0;
    logic [7:0] cfg_interval = 8'd0;
    logic [7:0] cfg_maxwidth = 8'd255;
    logic       cfg_invert = 1'b0;
    logic       pulse_v_o, pulse_w_o, fifo_ovf_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pulse_spreader dut (
        .clk(clk), .rst_n(rst_n), .ce_tick(ce_tick), .frame_start(frame_start),
        .upd_wr(upd_wr), .upd_v(upd_v), .upd_w(upd_w),
        .cfg_interval(cfg_interval), .cfg_maxwidth(cfg_maxwidth), .cfg_invert(cfg_invert),
        .pulse_v_o(pulse_v_o), .pulse_w_o(pulse_w_o), .fifo_ovf_o(fifo_ovf_o)
    );

    // ---------------- expected model built from the requirements ----------------
    int m_ivl = 0, m_mw = 255, m_cnt = 0, m_lim = 0;
    bit m_inv = 0, m_ovf = 0;
    bit m_lvl [2];
    int m_w   [2];
    bit m_q   [2][8];
    int m_n   [2];

    function automatic bit exp_pin(int ch);
        return m_inv ? m_lvl[ch] : !m_lvl[ch];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ivl = 0; m_mw = 255; m_cnt = 0; m_lim = 0; m_inv = 0; m_ovf = 0;
            for (int c = 0; c < 2; c++) begin m_lvl[c] = 0; m_w[c] = 0; m_n[c] = 0; end
        end else begin
            bit byp, slot, lim_en, push;
            int ncnt;
            bit bits [2];
            int nb0;
            byp    = (m_ivl == 0);
            slot   = 0;
            ncnt   = m_cnt;
            lim_en = !byp && (m_mw != 255);
            push   = upd_wr && !byp;
            bits[0] = upd_v; bits[1] = upd_w;
            nb0    = m_n[0];
            if (!frame_start && !byp && ce_tick) begin
                if (m_cnt == 1) begin slot = 1; ncnt = m_ivl * 4; end
                else ncnt = m_cnt - 1;
            end
            for (int c = 0; c < 2; c++) begin
                bit pop;
                int nb;
                pop = slot && (m_n[c] > 0);
                nb  = m_n[c];
                if (byp) begin
                    if (upd_wr) begin m_lvl[c] = bits[c]; m_w[c] = 0; end
                end else if (pop) begin
                    m_lvl[c] = m_q[c][0]; m_w[c] = 0;
                end else if (m_lvl[c] && lim_en && ce_tick) begin
                    if (m_w[c] + 1 >= m_lim) begin m_lvl[c] = 0; m_w[c] = 0; end
                    else m_w[c] = m_w[c] + 1;
                end
                if (frame_start) begin
                    m_n[c] = 0;
                    if (push) begin m_q[c][0] = bits[c]; m_n[c] = 1; end
                end else begin
                    if (pop) begin
                        for (int i = 0; i < 7; i++) m_q[c][i] = m_q[c][i+1];
                        m_n[c] = m_n[c] - 1;
                    end
                    if (push && nb < 8) begin m_q[c][m_n[c]] = bits[c]; m_n[c] = m_n[c] + 1; end
                end
            end
            if (frame_start) m_ovf = 0;
            else if (push && nb0 == 8) m_ovf = 1;
            if (frame_start) begin
                m_ivl = cfg_interval; m_mw = cfg_maxwidth; m_inv = cfg_invert;
                m_lim = (2 * m_mw + 1) * 4 * m_ivl;
                ncnt  = m_ivl * 4;
            end
            m_cnt = ncnt;
        end
    end

    task automatic check(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R3 R4 R6 R8 R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3", pulse_v_o, exp_pin(0));
            check("R4", pulse_w_o, exp_pin(1));
            check("R10", fifo_ovf_o, m_ovf);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_go(int ivl, int mw, bit inv);
        cfg_interval = 8'(ivl); cfg_maxwidth = 8'(mw); cfg_invert = inv;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic write1(bit v, bit w);
        upd_wr = 1'b1; upd_v = v; upd_w = w;
        @(negedge clk);
        upd_wr = 1'b0;
    endtask

    initial begin
        bit pat6 [6];
        bit pat9 [9];
        pat6 = '{1, 0, 1, 0, 1, 0};
        pat9 = '{1, 1, 1, 1, 1, 1, 1, 0, 1};
        void'($urandom(32'd20240611));
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1", pulse_v_o, 1'b1);
        check("R1", pulse_w_o, 1'b1);
        check("R1", fifo_ovf_o, 1'b0);

        // R2 direct mode, independent of tick; R7 no limit in direct mode
        ce_tick = 1'b1;
        write1(1, 0);
        check("R2", pulse_v_o, 1'b0);
        check("R2", pulse_w_o, 1'b1);
        cyc(40);
        check("R7", pulse_v_o, 1'b0);
        ce_tick = 1'b0;
        write1(0, 1);
        check("R2", pulse_v_o, 1'b1);
        check("R2", pulse_w_o, 1'b0);
        ce_tick = 1'b1;
        write1(0, 0);
        check("R2", pulse_w_o, 1'b1);

        // R4 / R5: 1950-tick frame, six updates, spacing 81 then 82
        frame_go(81, 255, 0);
        for (int i = 0; i < 6; i++) write1(pat6[i], pat6[i]);
        cyc(317);
        check("R4", pulse_v_o, 1'b1);
        cyc(1);
        check("R4", pulse_v_o, 1'b0);
        cyc(1625);
        frame_go(82, 255, 0);
        check("R5", pulse_v_o, 1'b1);
        for (int i = 0; i < 6; i++) write1(pat6[i], pat6[i]);
        cyc(1943);
        frame_go(0, 255, 0);
        check("R5", pulse_v_o, 1'b0);
        write1(0, 0);
        check("R5", pulse_v_o, 1'b1);

        // R6 width limit: I=1, M=2 -> 20 ticks
        frame_go(1, 2, 0);
        write1(1, 1);
        cyc(2);
        check("R6", pulse_v_o, 1'b1);
        cyc(1);
        check("R6", pulse_v_o, 1'b0);
        cyc(19);
        check("R6", pulse_v_o, 1'b0);
        cyc(1);
        check("R6", pulse_v_o, 1'b1);
        check("R6", pulse_w_o, 1'b1);

        // R7 code 255: no limit
        frame_go(1, 255, 0);
        write1(1, 1);
        cyc(199);
        check("R7", pulse_v_o, 1'b0);
        frame_go(0, 255, 0);
        write1(0, 0);

        // R9 mid-frame changes ignored; R8 polarity
        cfg_interval = 8'd5;
        write1(1, 0);
        check("R9", pulse_v_o, 1'b0);
        write1(0, 0);
        check("R9", pulse_v_o, 1'b1);
        cfg_invert = 1'b1;
        cyc(3);
        check("R9", pulse_v_o, 1'b1);
        frame_go(0, 255, 1);
        check("R8", pulse_v_o, 1'b0);
        write1(1, 0);
        check("R8", pulse_v_o, 1'b1);
        check("R8", pulse_w_o, 1'b0);
        write1(0, 0);
        check("R8", pulse_v_o, 1'b0);
        frame_go(0, 255, 0);
        check("R8", pulse_v_o, 1'b1);

        // R10 overflow: ninth write dropped
        frame_go(5, 255, 0);
        for (int i = 0; i < 9; i++) begin
            write1(pat9[i], pat9[i]);
            if (i == 7) check("R10", fifo_ovf_o, 1'b0);
            if (i == 8) check("R10", fifo_ovf_o, 1'b1);
        end
        cyc(136);
        check("R3", pulse_v_o, 1'b0);
        cyc(20);
        check("R3", pulse_v_o, 1'b1);
        cyc(20);
        check("R10", pulse_v_o, 1'b1);
        check("R10", fifo_ovf_o, 1'b1);
        frame_go(0, 255, 0);
        check("R10", fifo_ovf_o, 1'b0);

        // R4 no ticks: outputs hold
        ce_tick = 1'b0;
        frame_go(1, 255, 0);
        write1(1, 1);
        cyc(49);
        check("R4", pulse_v_o, 1'b1);
        ce_tick = 1'b1;
        cyc(3);
        check("R4", pulse_v_o, 1'b1);
        cyc(1);
        check("R4", pulse_v_o, 1'b0);
        frame_go(0, 255, 0);
        write1(0, 0);

        // constrained random frames, checked against the model every cycle
        for (int f = 0; f < 8; f++) begin
            int len;
            upd_wr = 1'b0;
            frame_go(($urandom % 4 == 0) ? 0 : 1 + $urandom % 6,
                     ($urandom % 3 == 0) ? 255 : $urandom % 4,
                     1'($urandom % 2));
            len = 80 + $urandom % 200;
            for (int k = 0; k < len; k++) begin
                upd_wr  = ($urandom % 6 == 0);
                upd_v   = 1'($urandom % 2);
                upd_w   = 1'($urandom % 2);
                ce_tick = ($urandom % 4 != 0);
                if ($urandom % 50 == 0) cfg_interval = 8'($urandom % 8);
                @(negedge clk);
            end
            upd_wr = 1'b0;
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule